// File: doc/BRIEF.md
# Look-ahead pipelined first-order low-pass filter

This block smooths a stream of signed fixed-point samples with a single-pole low-pass response. The one-sample feedback of the plain recurrence y[n] = (1-a)·x[n] + a·y[n-1] is rewritten by look-ahead as y[n] = a^N·y[n-N] + ((1-a^N)/N)·(x[n] + ... + x[n-N+1]). The output now depends on its own value N samples back, so the feedback loop can hold N registers and its multiplier and adder can be split across them without changing the response.

The caller supplies the depth N, the loop coefficient a^N and the feed-forward gain (1-a^N)/N as unsigned Q1.17 parameters. A boxcar sum of the last N accepted inputs feeds the loop. For N = 2 this sum puts a zero at z = -1, so the response stays low-pass with a null at half the sample rate. Each accepted sample produces one output a fixed number of clocks later. Clocks with the input strobe low do not advance the filter.

Top module: `lookahead_lpf`

## Requirements
- R1: For the n-th accepted sample, the output is sat(rnd(G·s[n]) + rnd(A·y[n-N])). Here A and G are the Q1.17 parameters A_N and G_N, rnd(p) = floor((p + 2^16) / 2^17), and sat clamps to the signed DW-bit range. Inputs and outputs before the first sample after reset count as zero.
- R2: s[n] is the exact sum of the last N accepted inputs x[n] ... x[n-N+1], with no rounding and no wrap.
- R3: An output for a sample driven before clock edge e appears with out_valid high right after edge e+3, which is 4 clocks of latency. No output appears at any other time.
- R4: After reset, the first N accepted samples produce no out_valid pulse. Every later accepted sample produces exactly one.
- R5: In a clock where no output is due, out_data keeps its value.
- R6: The output saturates at 32767 / -32768 and never wraps. With a gain that drives the steady state past full scale, a constant positive input gives 32767 and a constant negative input gives -32768, and the output never takes the opposite sign.
- R7: With the default coefficients (a = 0.75, N = 2), a constant input settles within 2 LSB of the input level. The residual comes from the rounding deadband.
- R8: With N = 2, an input that alternates +X, -X gives a zero boxcar sum, so the output decays to within 1 LSB of zero.
- R9: Synchronous reset clears the input, sum, loop and valid registers. out_valid and out_data read 0 during reset, and the filter restarts from a zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DW | Signed filtered sample |

## Verification
The assertions rely on two assumptions about the inputs. The first is that the strobe is the only qualifier, so samples in clocks where it is low are never used. The second is that an output changes only four clocks after an accepted sample, unless reset intervenes. The stimulus drives the strobe and data only on the falling edge. It mixes unbroken streams with gapped streams and places resets between phases and inside one stream. Constant, alternating and pseudo-random samples span the full signed input range. A second instance with a larger gain is the only one pushed into saturation.

// File: rtl/lookahead_lpf.sv
module lookahead_lpf #(
  parameter int DW = 16,
  parameter int N = 2,
  parameter int CW = 18,
  parameter logic [CW-1:0] A_N = 18'd73728,
  parameter logic [CW-1:0] G_N = 18'd28672
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int FB   = CW - 1;
  localparam int SW   = DW + $clog2(N) + 1;
  localparam int PW   = SW + CW + 1;
  localparam int QW   = DW + CW + 1;
  localparam int FFW  = SW + 2;
  localparam int FBW  = DW + 2;
  localparam int AW   = FFW + 1;
  localparam int LQ   = (N > 1) ? N - 1 : 1;
  localparam int CNTW = $clog2(N + 1);

  localparam logic signed [PW-1:0] GCOEF = PW'({1'b0, G_N});
  localparam logic signed [QW-1:0] ACOEF = QW'({1'b0, A_N});
  localparam logic signed [PW-1:0] HALFP = PW'(longint'(1) << (FB - 1));
  localparam logic signed [QW-1:0] HALFQ = QW'(longint'(1) << (FB - 1));
  localparam logic signed [AW-1:0] YMAX  = AW'((longint'(1) << (DW - 1)) - 1);
  localparam logic signed [AW-1:0] YMIN  = -AW'(longint'(1) << (DW - 1));
  localparam logic signed [SW-1:0] SMAX  = SW'(longint'(N) * ((longint'(1) << (DW - 1)) - 1));
  localparam logic signed [SW-1:0] SMIN  = -SW'(longint'(N) * (longint'(1) << (DW - 1)));

  logic signed [DW-1:0]  xr;
  logic signed [DW-1:0]  xd [N];
  logic signed [SW-1:0]  s_r;
  logic signed [FFW-1:0] ff_r;
  logic signed [FBW-1:0] fb_q;
  logic signed [DW-1:0]  yq [LQ];
  logic signed [AW-1:0]  acc;
  logic signed [DW-1:0]  ynew;
  logic                  v1, v2, v3, ov;
  logic [CNTW-1:0]       cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      xr <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) xr <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2  <= 1'b0;
      s_r <= '0;
      for (int i = 0; i < N; i++) xd[i] <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        s_r   <= s_r + SW'(xr) - SW'(xd[N-1]);
        xd[0] <= xr;
        for (int i = 1; i < N; i++) xd[i] <= xd[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v3   <= 1'b0;
      ff_r <= '0;
    end else begin
      v3 <= v2;
      if (v2) ff_r <= FFW'((PW'(s_r) * GCOEF + HALFP) >>> FB);
    end
  end

  generate
    if (N == 1) begin : g_comb_fb
      assign fb_q = FBW'((QW'(yq[LQ-1]) * ACOEF + HALFQ) >>> FB);
    end else begin : g_reg_fb
      always_ff @(posedge clk) begin
        if (rst) fb_q <= '0;
        else if (v3) fb_q <= FBW'((QW'(yq[LQ-1]) * ACOEF + HALFQ) >>> FB);
      end
    end
  endgenerate

  assign acc  = AW'(ff_r) + AW'(fb_q);
  assign ynew = (acc > YMAX) ? YMAX[DW-1:0] : (acc < YMIN) ? YMIN[DW-1:0] : acc[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ov  <= 1'b0;
      cnt <= '0;
      for (int i = 0; i < LQ; i++) yq[i] <= '0;
    end else begin
      ov <= v3 && (cnt == CNTW'(N));
      if (v3) begin
        if (cnt != CNTW'(N)) cnt <= cnt + 1'b1;
        yq[0] <= ynew;
        for (int i = 1; i < LQ; i++) yq[i] <= yq[i-1];
      end
    end
  end

  assign out_valid = ov;
  assign out_data  = yq[0];

  assert_sum_range_R2: assert property (@(posedge clk) disable iff (rst)
    (s_r <= SMAX) && (s_r >= SMIN))
    else $error("moving sum left its range");

  assert_out_latency_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 4))
    else $error("output without a sample four clocks earlier");

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid, 4)) |-> $stable(out_data))
    else $error("output moved with no sample due");

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (v3 && ff_r >= 0 && fb_q >= 0) |=> !out_data[DW-1])
    else $error("non-negative terms gave a negative output");

  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0))
    else $error("reset left output state");
endmodule

// File: tb/sim_lookahead_lpf.sv
`timescale 1ns/1ps
module sim_lookahead_lpf;
  localparam int  N  = 2;
  localparam longint A  = 73728;
  localparam longint G  = 28672;
  localparam longint G1 = 65536;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic out_valid, u1_valid;
  logic signed [15:0] out_data, u1_data;

  always #10 clk = ~clk;

  lookahead_lpf #(.DW(16), .N(N), .CW(18), .A_N(18'(A)), .G_N(18'(G))) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  lookahead_lpf #(.DW(16), .N(N), .CW(18), .A_N(18'(A)), .G_N(18'(G1))) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(u1_valid), .out_data(u1_data));

  int ncmp = 0, nbad = 0, cyc = 0, nsamp = 0, nout = 0;
  longint xh [N];
  longint yh [N];
  longint qv [$];
  int     qc [$];
  bit [3:0] hist;
  longint last_out;
  logic [31:0] lf = 32'h1234_5678;
  bit sat_chk = 0;
  longint sat_sign = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    ncmp++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  function automatic longint rnd(input longint p);
    return (p + 65536) >>> 17;
  endfunction

  function automatic longint model(input longint x);
    longint s, y;
    for (int i = N - 1; i > 0; i--) xh[i] = xh[i-1];
    xh[0] = x;
    s = 0;
    for (int i = 0; i < N; i++) s += xh[i];
    y = rnd(G * s) + rnd(A * yh[N-1]);
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    for (int i = N - 1; i > 0; i--) yh[i] = yh[i-1];
    yh[0] = y;
    return y;
  endfunction

  task automatic do_reset();
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid in reset", longint'(out_valid), 0);
    chk(out_data == 0, "R9 data in reset", longint'(out_data), 0);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin xh[i] = 0; yh[i] = 0; end
    qv.delete(); qc.delete();
    hist = '0; last_out = 0; nsamp = 0; nout = 0;
  endtask

  task automatic tick(input bit v, input longint x);
    @(negedge clk);
    if (out_valid) begin
      if (qv.size() == 0) chk(1'b0, "R4 unexpected output", longint'(out_data), 0);
      else begin
        longint e; int c;
        e = qv.pop_front(); c = qc.pop_front();
        chk(out_data == e, "R1 R2 data", longint'(out_data), e);
        chk(cyc == c, "R3 latency", cyc, c);
      end
      nout++;
    end else if (!hist[3]) begin
      chk(out_data == last_out, "R5 hold", longint'(out_data), last_out);
    end
    if (sat_chk && u1_valid)
      chk(longint'(u1_data) * sat_sign >= 0, "R6 no wrap", longint'(u1_data), sat_sign);
    last_out = out_data;
    in_valid = v;
    in_data = 16'(x);
    hist = {hist[2:0], v};
    if (v) begin
      longint y;
      y = model(x);
      if (nsamp >= N) begin qv.push_back(y); qc.push_back(cyc + 4); end
      nsamp++;
    end
    cyc++;
  endtask

  task automatic flush_and_count(input string tag);
    repeat (8) tick(1'b0, 0);
    chk(nout == ((nsamp > N) ? nsamp - N : 0), tag, nout, (nsamp > N) ? nsamp - N : 0);
    chk(qv.size() == 0, "R3 drained", qv.size(), 0);
  endtask

  function automatic logic [31:0] step_lf(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic const_run(input longint x, input int len);
    for (int k = 0; k < len; k++) tick(1'b1, x);
  endtask

  initial begin
    #3ms;
    nbad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    do_reset();
    tick(1'b0, 0);
    chk(out_valid == 1'b0 && out_data == 0, "R9 after release", longint'(out_data), 0);

    for (int k = 0; k < 400; k++) begin
      lf = step_lf(lf);
      tick(1'b1, longint'($signed(lf[15:0])));
    end
    flush_and_count("R4 output count dense");

    do_reset();
    for (int k = 0; k < 500; k++) begin
      lf = step_lf(lf);
      tick(lf[20] | lf[21], longint'($signed(lf[15:0])));
    end
    flush_and_count("R4 R5 output count gapped");

    do_reset();
    tick(1'b1, 5000);
    tick(1'b1, -7000);
    chk(qv.size() == 0, "R4 warmup pending", qv.size(), 0);
    flush_and_count("R4 warmup only");

    do_reset();
    const_run(1000, 200);
    flush_and_count("R4 count step");
    chk(last_out >= 998 && last_out <= 1002, "R7 step 1000", last_out, 1000);

    do_reset();
    const_run(-12345, 200);
    flush_and_count("R4 count step");
    chk(last_out >= -12347 && last_out <= -12343, "R7 step -12345", last_out, -12345);

    do_reset();
    const_run(-32768, 200);
    flush_and_count("R4 count step");
    chk(last_out >= -32768 && last_out <= -32766, "R7 step full scale", last_out, -32768);

    do_reset();
    const_run(20000, 100);
    for (int k = 0; k < 200; k++) tick(1'b1, (k % 2) ? -20000 : 20000);
    flush_and_count("R4 count alternating");
    chk(last_out >= -1 && last_out <= 1, "R8 alternating null", last_out, 0);

    do_reset();
    sat_chk = 1; sat_sign = 1;
    const_run(20000, 200);
    flush_and_count("R4 count saturate");
    chk(u1_data == 32767, "R6 positive clamp", longint'(u1_data), 32767);
    do_reset();
    sat_sign = -1;
    const_run(-20000, 200);
    flush_and_count("R4 count saturate");
    chk(u1_data == -32768, "R6 negative clamp", longint'(u1_data), -32768);
    sat_chk = 0;

    do_reset();
    for (int k = 0; k < 60; k++) begin
      lf = step_lf(lf);
      tick(1'b1, longint'($signed(lf[15:0])));
    end
    do_reset();
    for (int k = 0; k < 120; k++) begin
      lf = step_lf(lf);
      tick(lf[3], longint'($signed(lf[15:0])));
    end
    flush_and_count("R9 R4 restart count");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule